// File: doc/BRIEF.md
# Pixel Matrix Configuration Controller

This block sits behind a serial slave interface and carries out the commands it delivers. Each operation arrives as a 7-bit command, a 12-bit address, a write flag and a 32-bit data word, and it is qualified by an execute strobe. The controller decodes the operation and sends it to one of three places. It can go to a small file of configuration words. It can go to the row and column pointer registers that drive the pixel selection decoders. It can go to a pixel configuration write or read. The controller answers with an acknowledge and, for reads, a data word.

The command, address and data buffers load only on the cycle in which the execute strobe is first seen high, so the internal logic stays quiet between operations. A pixel operation takes the form of one selection cycle. In that cycle the one-hot row and column selects are valid. For writes, the cycle also carries a write enable and the pixel data word. Broadcast commands assert every line of one or both select buses.

The FSM has four states. IDLE waits for the strobe and loads the buffers on the cycle it arrives (transition IDLE to EXEC). EXEC decodes the command. For a pixel command it loads the pointers and moves to PIXEL (transition EXEC to PIXEL). For any other command it performs the action and moves to ACK (transition EXEC to ACK). PIXEL drives the selection cycle and moves to ACK (transition PIXEL to ACK). ACK holds the acknowledge while the strobe stays high and returns to IDLE when the strobe falls (transition ACK to IDLE).

Top module: `pixcfg_ctrl`

## Requirements
- R1: Only bits [3:0] of `cmd_i` are decoded. Bits [6:4] have no effect, so command 7'h45 acts exactly like command 5.
- R2: Command codes 0 and 1 both access the configuration word file. When `wr_i`=1 the word at `addr_i[3:0]` is written with `wdata_i`. When `wr_i`=0 that word is returned on `rdata_o`. Address bits [11:4] are ignored.
- R3: After reset, configuration word i holds 32'hC0F1_0000 + i.
- R4: Let the strobe first be sampled high at clock edge N. For commands that are not pixel commands, `ack_o` rises at edge N+1. For pixel commands (2, 3, 4, 5) it rises at edge N+2. Once high, `ack_o` stays high while `exec_i` is high and falls at the edge after `exec_i` is sampled low.
- R5: Command 2 (one row, all columns) produces one selection cycle. In that cycle `row_sel_o` is one-hot at `addr_i[6:0]` and `col_sel_o` is all ones.
- R6: Command 3 (one column, all rows) produces one selection cycle. In that cycle `col_sel_o` is one-hot at `addr_i[11:7]` and `row_sel_o` is all ones.
- R7: Command 4 (whole matrix) produces one selection cycle with both select buses all ones.
- R8: Command 5 with `wr_i`=1 produces one selection cycle. In that cycle both selects are one-hot at the pointers, `pix_we_o`=1, and `pix_wdata_o` equals `wdata_i[5:0]`.
- R9: Command 5 with `wr_i`=0 samples `pix_rdata_i` during the selection cycle and returns it zero-extended on `rdata_o`. In that cycle `pix_we_o` stays 0.
- R10: Command 8 raises `cfg_end_o` for exactly one cycle, together with the rising edge of `ack_o`.
- R11: Any other command code is acknowledged with no side effect: no selection cycle and no word file change. A read of such a code returns 0.
- R12: While `exec_i` is low, input changes have no effect. Outside the selection cycle both select buses, `pix_en_o`, `pix_we_o` and `pix_wdata_o` are 0. `rdata_o` is 0 whenever `ack_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| exec_i | input | 1 | Execute strobe from the serial slave |
| wr_i | input | 1 | 1 = write, 0 = read |
| cmd_i | input | 7 | Command code (low 4 bits decoded) |
| addr_i | input | 12 | Word index or packed row/column pointer |
| wdata_i | input | 32 | Write data |
| pix_rdata_i | input | 6 | Configuration bits read back from the selected pixel |
| ack_o | output | 1 | Acknowledge |
| rdata_o | output | 32 | Read data, valid while `ack_o` is high |
| row_sel_o | output | 128 | Row select lines |
| col_sel_o | output | 32 | Column select lines |
| pix_en_o | output | 1 | Selection cycle active |
| pix_we_o | output | 1 | Pixel write enable |
| pix_wdata_o | output | 6 | Pixel configuration bits to write |
| cfg_end_o | output | 1 | End-of-configuration pulse |

## Verification
The word file is exercised with a table of operations. The table mixes the two access codes, commands with noisy upper bits and addresses with noisy upper bits, so a decoder that reads too many bits returns the wrong word. Undefined codes are sent as both reads and writes and then followed by a read-back, which separates "acknowledged and ignored" from "silently written". Each pixel command is sent with one asymmetric row/column pair. This exposes swapped pointer fields and a broadcast applied to the wrong axis. Separate cases measure acknowledge latency, check the one-cycle length of the pulses, and show that inputs are ignored while the strobe is low.

// File: rtl/pixcfg_pkg.sv
package pixcfg_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_EXEC  = 2'd1,
        S_PIXEL = 2'd2,
        S_ACK   = 2'd3
    } ctl_state_t;

    localparam logic [3:0] OP_WORD_A  = 4'd0;
    localparam logic [3:0] OP_WORD_B  = 4'd1;
    localparam logic [3:0] OP_ROW_ALL = 4'd2;
    localparam logic [3:0] OP_COL_ALL = 4'd3;
    localparam logic [3:0] OP_MATRIX  = 4'd4;
    localparam logic [3:0] OP_PIXEL   = 4'd5;
    localparam logic [3:0] OP_CFG_END = 4'd8;

    function automatic logic is_word_op(input logic [3:0] op);
        return (op == OP_WORD_A) || (op == OP_WORD_B);
    endfunction

    function automatic logic is_pix_op(input logic [3:0] op);
        return (op == OP_ROW_ALL) || (op == OP_COL_ALL) ||
               (op == OP_MATRIX)  || (op == OP_PIXEL);
    endfunction

endpackage

// File: rtl/pixcfg_cmd_buf.sv
module pixcfg_cmd_buf #(
    parameter int AW = 12,
    parameter int DW = 32,
    parameter int OPW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          wr_i,
    input  logic [OPW-1:0] op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          wr_q,
    output logic [OPW-1:0] op_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q
);
    // Command/address buffer: loads only on an execute cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            op_q   <= '0;
            addr_q <= '0;
        end else if (load_i) begin
            wr_q   <= wr_i;
            op_q   <= op_i;
            addr_q <= addr_i;
        end
    end

    // Data buffer: only takes the bus in write mode.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdata_q <= '0;
        end else if (load_i && wr_i) begin
            wdata_q <= wdata_i;
        end
    end
endmodule

// File: rtl/pixcfg_word_file.sv
module pixcfg_word_file #(
    parameter int          WORDS    = 16,
    parameter int          DW       = 32,
    parameter logic [31:0] RST_BASE = 32'hC0F1_0000,
    localparam int         IW       = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] words [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [DW-1:0] RST_VAL = DW'(RST_BASE + 32'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words[g] <= RST_VAL;
            end else if (we_i && (idx_i == IW'(g))) begin
                words[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = words[idx_i];
endmodule

// File: rtl/pixcfg_sel_dec.sv
module pixcfg_sel_dec #(
    parameter int N  = 128,
    localparam int IW = $clog2(N)
) (
    input  logic          en_i,
    input  logic          all_i,
    input  logic [IW-1:0] idx_i,
    output logic [N-1:0]  sel_o
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign sel_o[g] = en_i & (all_i | (idx_i == IW'(g)));
    end
endmodule

// File: rtl/pixcfg_ctrl.sv
module pixcfg_ctrl #(
    parameter int          ROWS     = 128,
    parameter int          COLS     = 32,
    parameter int          AW       = 12,
    parameter int          DW       = 32,
    parameter int          CMDW     = 7,
    parameter int          WORDS    = 16,
    parameter int          PIXW     = 6,
    parameter logic [31:0] RST_BASE = 32'hC0F1_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            exec_i,
    input  logic            wr_i,
    input  logic [CMDW-1:0] cmd_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [PIXW-1:0] pix_rdata_i,
    output logic            ack_o,
    output logic [DW-1:0]   rdata_o,
    output logic [ROWS-1:0] row_sel_o,
    output logic [COLS-1:0] col_sel_o,
    output logic            pix_en_o,
    output logic            pix_we_o,
    output logic [PIXW-1:0] pix_wdata_o,
    output logic            cfg_end_o
);
    import pixcfg_pkg::*;

    localparam int OPW = 4;
    localparam int RIW = $clog2(ROWS);
    localparam int CIW = $clog2(COLS);
    localparam int WIW = $clog2(WORDS);

    ctl_state_t state_q, state_d;

    logic            load;
    logic            wr_q;
    logic [OPW-1:0]  op_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic            word_we;
    logic [DW-1:0]   word_rd;

    logic            ack_q;
    logic [DW-1:0]   rdata_q;
    logic            cfg_end_q;
    logic [RIW-1:0]  row_ptr_q;
    logic [CIW-1:0]  col_ptr_q;
    logic            row_all_q;
    logic            col_all_q;

    assign load = exec_i && (state_q == S_IDLE);

    pixcfg_cmd_buf #(
        .AW (AW),
        .DW (DW),
        .OPW(OPW)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .wr_i   (wr_i),
        .op_i   (cmd_i[OPW-1:0]),
        .addr_i (addr_i),
        .wdata_i(wdata_i),
        .wr_q   (wr_q),
        .op_q   (op_q),
        .addr_q (addr_q),
        .wdata_q(wdata_q)
    );

    assign word_we = (state_q == S_EXEC) && wr_q && is_word_op(op_q);

    pixcfg_word_file #(
        .WORDS   (WORDS),
        .DW      (DW),
        .RST_BASE(RST_BASE)
    ) u_words (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (word_we),
        .idx_i  (addr_q[WIW-1:0]),
        .wdata_i(wdata_q),
        .rdata_o(word_rd)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (exec_i) state_d = S_EXEC;
            S_EXEC:  state_d = is_pix_op(op_q) ? S_PIXEL : S_ACK;
            S_PIXEL: state_d = S_ACK;
            S_ACK:   if (!exec_i) state_d = S_IDLE;
        endcase
    end

    // Registered outputs and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q     <= 1'b0;
            rdata_q   <= '0;
            cfg_end_q <= 1'b0;
            row_ptr_q <= '0;
            col_ptr_q <= '0;
            row_all_q <= 1'b0;
            col_all_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    cfg_end_q <= 1'b0;
                end
                S_EXEC: begin
                    if (is_pix_op(op_q)) begin
                        row_ptr_q <= addr_q[RIW-1:0];
                        col_ptr_q <= addr_q[RIW +: CIW];
                        row_all_q <= (op_q == OP_COL_ALL) || (op_q == OP_MATRIX);
                        col_all_q <= (op_q == OP_ROW_ALL) || (op_q == OP_MATRIX);
                    end else begin
                        ack_q     <= 1'b1;
                        rdata_q   <= (is_word_op(op_q) && !wr_q) ? word_rd : '0;
                        cfg_end_q <= (op_q == OP_CFG_END);
                    end
                end
                S_PIXEL: begin
                    ack_q   <= 1'b1;
                    rdata_q <= wr_q ? '0 : DW'(pix_rdata_i);
                end
                S_ACK: begin
                    cfg_end_q <= 1'b0;
                    if (!exec_i) ack_q <= 1'b0;
                end
            endcase
        end
    end

    assign pix_en_o = (state_q == S_PIXEL);

    pixcfg_sel_dec #(.N(ROWS)) u_row_dec (
        .en_i (pix_en_o),
        .all_i(row_all_q),
        .idx_i(row_ptr_q),
        .sel_o(row_sel_o)
    );

    pixcfg_sel_dec #(.N(COLS)) u_col_dec (
        .en_i (pix_en_o),
        .all_i(col_all_q),
        .idx_i(col_ptr_q),
        .sel_o(col_sel_o)
    );

    assign pix_we_o    = pix_en_o && wr_q;
    assign pix_wdata_o = pix_we_o ? wdata_q[PIXW-1:0] : '0;
    assign ack_o       = ack_q;
    assign rdata_o     = ack_q ? rdata_q : '0;
    assign cfg_end_o   = cfg_end_q;
endmodule

// File: rtl/pixcfg_ctrl_chk.sv
module pixcfg_ctrl_chk #(
    parameter int ROWS = 128,
    parameter int COLS = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exec_i,
    input logic            ack_o,
    input logic [ROWS-1:0] row_sel_o,
    input logic [COLS-1:0] col_sel_o,
    input logic            pix_en_o,
    input logic            pix_we_o,
    input logic            cfg_end_o
);
    p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && exec_i) |=> ack_o);

    p_ack_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && !exec_i) |=> !ack_o);

    p_sel_cycle_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en_o |=> !pix_en_o);

    p_sel_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_en_o |-> ((row_sel_o != '0) && (col_sel_o != '0)));

    p_end_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_end_o |=> !cfg_end_o);

    p_end_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_end_o |-> ack_o);

    p_sel_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en_o |-> ((row_sel_o == '0) && (col_sel_o == '0) && !pix_we_o));

    p_no_sel_with_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !pix_en_o);
endmodule

bind pixcfg_ctrl pixcfg_ctrl_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .exec_i   (exec_i),
    .ack_o    (ack_o),
    .row_sel_o(row_sel_o),
    .col_sel_o(col_sel_o),
    .pix_en_o (pix_en_o),
    .pix_we_o (pix_we_o),
    .cfg_end_o(cfg_end_o)
);

// File: tb/pixcfg_ctrl_tb_top.sv
module pixcfg_ctrl_tb_top;
    localparam int ROWS = 128;
    localparam int COLS = 32;
    localparam int PIXW = 6;
    localparam logic [31:0] RBASE = 32'hC0F1_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            exec_i = 1'b0;
    logic            wr_i = 1'b0;
    logic [6:0]      cmd_i = '0;
    logic [11:0]     addr_i = '0;
    logic [31:0]     wdata_i = '0;
    logic [PIXW-1:0] pix_rdata_i = '0;
    logic            ack_o;
    logic [31:0]     rdata_o;
    logic [ROWS-1:0] row_sel_o;
    logic [COLS-1:0] col_sel_o;
    logic            pix_en_o;
    logic            pix_we_o;
    logic [PIXW-1:0] pix_wdata_o;
    logic            cfg_end_o;

    always #10 clk = ~clk;

    pixcfg_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .wr_i(wr_i),
        .cmd_i(cmd_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .pix_rdata_i(pix_rdata_i), .ack_o(ack_o), .rdata_o(rdata_o),
        .row_sel_o(row_sel_o), .col_sel_o(col_sel_o), .pix_en_o(pix_en_o),
        .pix_we_o(pix_we_o), .pix_wdata_o(pix_wdata_o), .cfg_end_o(cfg_end_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Captures from the last operation
    int              c_lat;
    int              c_en_n;
    int              c_end_n;
    logic            c_we;
    logic [ROWS-1:0] c_row;
    logic [COLS-1:0] c_col;
    logic [PIXW-1:0] c_wd;
    logic [31:0]     c_rd;

    task automatic op(input logic w, input logic [6:0] c, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_i = w; cmd_i = c; addr_i = a; wdata_i = d; exec_i = 1'b1;
        c_lat = 0; c_en_n = 0; c_end_n = 0; c_we = 0;
        c_row = '0; c_col = '0; c_wd = '0; c_rd = '0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            // scramble inputs after the strobe is taken
            cmd_i = 7'h7F; addr_i = 12'hFFF; wdata_i = 32'hFFFF_FFFF;
            if (pix_en_o) begin
                c_en_n++; c_row = row_sel_o; c_col = col_sel_o;
                c_we = pix_we_o; c_wd = pix_wdata_o;
            end
            if (cfg_end_o) c_end_n++;
            if (ack_o) begin
                c_lat = i; c_rd = rdata_o;
                break;
            end
        end
        @(negedge clk);
        if (cfg_end_o) c_end_n++;
        chk("R4 ack held", 128'(ack_o), 128'd1);
        exec_i = 1'b0;
        @(negedge clk);
        chk("R4 ack drop", 128'(ack_o), 128'd0);
        chk("R12 rdata zero w/o ack", 128'(rdata_o), 128'd0);
    endtask

    // word table: wr, cmd, addr, wdata, expected read
    localparam int NT = 10;
    localparam logic [83:0] TBL [NT] = '{
        {1'b0, 7'h01, 12'h003, 32'h0,         32'hC0F1_0003},
        {1'b0, 7'h00, 12'hFF0, 32'h0,         32'hC0F1_0000},
        {1'b1, 7'h00, 12'h003, 32'h1234_5678, 32'h0},
        {1'b0, 7'h01, 12'hF03, 32'h0,         32'h1234_5678},
        {1'b1, 7'h70, 12'h0A5, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 7'h11, 12'h005, 32'h0,         32'hDEAD_BEEF},
        {1'b0, 7'h06, 12'h003, 32'h0,         32'h0},
        {1'b1, 7'h0E, 12'h003, 32'hAAAA_5555, 32'h0},
        {1'b0, 7'h21, 12'h003, 32'h0,         32'h1234_5678},
        {1'b0, 7'h01, 12'h00F, 32'h0,         32'hC0F1_000F}
    };

    initial begin : wdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // reset state
        chk("R12 reset ack", 128'(ack_o), 128'd0);
        chk("R12 reset row sel", 128'(row_sel_o), 128'd0);
        chk("R12 reset col sel", 128'(col_sel_o), 128'd0);
        chk("R12 reset end", 128'(cfg_end_o), 128'd0);
        rst_n = 1'b1;

        // R2/R3/R11/R1: table walk
        for (int k = 0; k < NT; k++) begin
            op(TBL[k][83], TBL[k][82:76], TBL[k][75:64], TBL[k][63:32]);
            chk("R4 word latency", 128'(c_lat), 128'd2);
            chk("R11 no sel cycle on non-pixel op", 128'(c_en_n), 128'd0);
            chk("R2/R3 read data", 128'(c_rd), 128'(TBL[k][31:0]));
        end

        // R12: inputs wiggled with strobe low
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            wr_i = i[0]; cmd_i = 7'(i + 2); addr_i = 12'(i * 300); wdata_i = 32'(i);
            @(negedge clk);
            chk("R12 ignored ack", 128'(ack_o), 128'd0);
            chk("R12 ignored sel", 128'(pix_en_o | (|row_sel_o) | cfg_end_o), 128'd0);
        end
        op(1'b0, 7'h00, 12'h002, 32'h0);
        chk("R12 word intact", 128'(c_rd), 128'(RBASE + 32'd2));

        // R5: one row, all columns (row 77, col 9)
        op(1'b1, 7'h02, {5'd9, 7'd77}, 32'h0000_0015);
        chk("R4 pixel latency", 128'(c_lat), 128'd3);
        chk("R5 one sel cycle", 128'(c_en_n), 128'd1);
        chk("R5 row one-hot", 128'(c_row), 128'd1 << 77);
        chk("R5 col all", 128'(c_col), 128'({COLS{1'b1}}));
        chk("R5 pixel data", 128'(c_wd), 128'h15);

        // R6: one column, all rows
        op(1'b1, 7'h03, {5'd9, 7'd77}, 32'h0000_002A);
        chk("R6 col one-hot", 128'(c_col), 128'd1 << 9);
        chk("R6 row all", 128'(c_row), {ROWS{1'b1}});

        // R7: whole matrix
        op(1'b1, 7'h04, 12'h000, 32'h0000_003F);
        chk("R7 row all", 128'(c_row), {ROWS{1'b1}});
        chk("R7 col all", 128'(c_col), 128'({COLS{1'b1}}));
        chk("R7 we", 128'(c_we), 128'd1);

        // R8: single pixel write at boundary pointers (row 127, col 31)
        op(1'b1, 7'h05, {5'd31, 7'd127}, 32'hFFFF_FFE9);
        chk("R8 row", 128'(c_row), 128'd1 << 127);
        chk("R8 col", 128'(c_col), 128'd1 << 31);
        chk("R8 we", 128'(c_we), 128'd1);
        chk("R8 data", 128'(c_wd), 128'h29);

        // R9: single pixel read (row 3, col 20)
        pix_rdata_i = 6'h2B;
        op(1'b0, 7'h05, {5'd20, 7'd3}, 32'h0);
        chk("R9 read data", 128'(c_rd), 128'h2B);
        chk("R9 no we", 128'(c_we), 128'd0);
        chk("R9 row", 128'(c_row), 128'd1 << 3);
        chk("R9 col", 128'(c_col), 128'd1 << 20);

        // R1: upper command bits ignored on a pixel read
        pix_rdata_i = 6'h11;
        op(1'b0, 7'h45, {5'd0, 7'd0}, 32'h0);
        chk("R1 cmd 45 acts as 5", 128'(c_rd), 128'h11);
        chk("R1 cmd 45 sel", 128'(c_row), 128'd1);

        // R10: end of configuration
        op(1'b1, 7'h08, 12'h000, 32'h0);
        chk("R10 end pulse count", 128'(c_end_n), 128'd1);
        chk("R10 latency", 128'(c_lat), 128'd2);
        chk("R10 no sel", 128'(c_en_n), 128'd0);

        // R11: undefined code, write then read-back
        op(1'b1, 7'h0C, 12'h004, 32'h0BAD_0BAD);
        chk("R11 no sel on undefined", 128'(c_en_n), 128'd0);
        op(1'b0, 7'h01, 12'h004, 32'h0);
        chk("R11 word unchanged", 128'(c_rd), 128'(RBASE + 32'd4));

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule